// File: doc/BRIEF.md
# SMBus Host Status and Interrupt Logic

This block keeps the host-side status byte of an SMBus host controller and drives its interrupt line. The bus engine reports four kinds of outcome as one-cycle pulses: normal completion, device error, bus collision, and a failure caused by software killing the transaction. Each outcome latches into its own sticky flag. The flag stays set until software writes a 1 to its bit position through the byte-wide register port. The interrupt output is the interrupt-enable bit ANDed with the OR of those four flags. Because every flag is set only by the engine, the interrupt can only rise after a transaction has really ended.

The busy bit follows bus activity, not the start request. When software asks for a start, the request waits for a configurable number of clock cycles (0 to 15). After that wait the block pulses a go strobe to the engine and sets busy. Busy drops on the cycle after any outcome pulse. So software that polls busy right after a start can see it idle, and software should rely on the interrupt instead. The block ignores a new start request while one is pending, while busy is set, or while the engine reports it is active. The status byte sits at one offset of the register port. Every other offset reads zero and ignores writes.

Top module: `smb_host_status`

## Requirements
- R1: After reset, the status byte reads 00h, `irq` is 0, `host_busy` is 0 and `eng_go` is 0.
- R2: A pulse on `ev_done`, `ev_dev_err`, `ev_collide` or `ev_kill_fail` sets status bit 1, 2, 3 or 4 respectively, and the bit reads 1 from the cycle after the pulse.
- R3: A write to the status offset clears each of bits 4..1 whose data bit is 1 and leaves the bits written 0 unchanged. A write to any other offset changes no flag.
- R4: When a set pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: Status bits 7..5 always read 0. Writes to bits 7..5 and bit 0 have no effect.
- R6: Status bit 0 equals `host_busy`. After a start request is accepted at clock edge k, `host_busy` stays 0 until edge k+LAT and reads 1 from that edge on. `eng_go` is high for exactly the one cycle that ends at edge k+LAT.
- R7: `host_busy` falls to 0 on the edge after any of the four outcome pulses, unless a launch happens in that same cycle.
- R8: A start request is ignored while a start is pending, while `host_busy` is 1, or while `eng_active` is 1. An ignored request neither restarts the wait nor produces an `eng_go` pulse.
- R9: `irq` equals `irq_en` AND the OR of status bits 4..1, combinationally, with no added cycle.
- R10: A read at any offset other than the status offset (0) returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register port offset |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ev_done | input | 1 | Engine pulse: last host command completed |
| ev_dev_err | input | 1 | Engine pulse: transaction error (bad command, unclaimed cycle, device time-out) |
| ev_collide | input | 1 | Engine pulse: bus collision |
| ev_kill_fail | input | 1 | Engine pulse: transaction ended by the kill control |
| start_req | input | 1 | Pulse: software wrote the start control |
| eng_active | input | 1 | Engine is currently occupied |
| irq_en | input | 1 | Interrupt-enable bit from the control register |
| eng_go | output | 1 | One-cycle launch strobe to the engine |
| host_busy | output | 1 | Host interface is processing a command |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the flag rules: an outcome pulse always sets its flag, and set takes priority over a same-cycle clear. A flag clears only through a write-1, and it never sets without a pulse. They also check that the pending state and busy never overlap, that busy never rises without a launch, and that an outcome pulse drops busy. On every cycle they also check that the interrupt never asserts without enable, that the reserved bits read zero, and that other offsets read zero. Only the bench scenarios can show the exact wait from start to busy for the chosen latency. They also show that a second start during the wait does not restart it, that starts during busy or engine activity produce no go strobe, and that reset in the middle of a run clears latched flags.

// File: rtl/smbst_pkg.sv
package smbst_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned MAX_LAT = 15;

  // Index of each outcome source inside the flag vector (flag i sits at status bit i+1)
  typedef enum int unsigned {
    SRC_DONE    = 0,
    SRC_DEVERR  = 1,
    SRC_COLLIDE = 2,
    SRC_KILLED  = 3
  } src_e;

  // Sticky cell update: a set pulse always wins over a clear request
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Status byte layout: reserved zeros on top, four flags, busy at bit 0
  function automatic logic [DATA_W-1:0] pack_status(input logic [NUM_SRC-1:0] flags,
                                                     input logic busy);
    return {{(DATA_W-NUM_SRC-1){1'b0}}, flags, busy};
  endfunction

  // Interrupt combine: enable gated with any latched outcome
  function automatic logic irq_combine(input logic en, input logic [NUM_SRC-1:0] flags);
    return en & (|flags);
  endfunction

endpackage

// File: rtl/smbst_flag_bank.sv
module smbst_flag_bank
  import smbst_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= sticky_next(flag_q, set_ev[i], clr_mask[i]);
    end

    assign flags[i] = flag_q;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]); // R2

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !set_ev[i]) |=> !flags[i]); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[i] && clr_mask[i]) |=> flags[i]); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && clr_mask[i] && !set_ev[i]) |=> !flags[i]); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_mask[i]) |=> flags[i]); // R3
  end

endmodule

// File: rtl/smbst_launch_timer.sv
module smbst_launch_timer
  import smbst_pkg::*;
#(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic eng_active,
  input  logic end_evt,
  output logic launch,
  output logic pending,
  output logic busy
);

  localparam int unsigned CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic accept;
  logic busy_q;
  logic pend_q;

  // A request is taken only when nothing is waiting, running or occupying the engine
  assign accept = start_req & ~busy_q & ~pend_q & ~eng_active;

  if (LAT == 0) begin : g_direct
    assign pend_q = 1'b0;
    assign launch = accept;
  end else begin : g_delayed
    logic [CNT_W-1:0] cnt_q;
    logic             pq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pq    <= 1'b0;
        cnt_q <= '0;
      end else if (accept) begin
        pq    <= 1'b1;
        cnt_q <= CNT_W'(LAT);
      end else if (pq) begin
        if (cnt_q == CNT_W'(1)) pq <= 1'b0;
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end

    assign pend_q = pq;
    assign launch = pq & (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (launch)  busy_q <= 1'b1;
    else if (end_evt) busy_q <= 1'b0;
  end

  assign busy    = busy_q;
  assign pending = pend_q;

  AST_BUSY_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(launch)); // R6

  AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && busy_q)); // R8

  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !launch) |=> !busy_q); // R7

  AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !end_evt) |=> busy_q); // R7

endmodule

// File: rtl/smbst_regport.sv
module smbst_regport
  import smbst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = 0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wflags,
  input  logic [DATA_W-1:0]  status,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_SRC-1:0] clr_mask
);

  logic sel;

  assign sel      = (addr == ADDR_W'(STAT_OFS));
  assign clr_mask = (wr && sel) ? wflags : '0;
  assign rdata    = sel ? status : '0;

endmodule

// File: rtl/smb_host_status.sv
module smb_host_status
  import smbst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned LAT      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  output logic [7:0]        reg_rdata,
  input  logic              ev_done,
  input  logic              ev_dev_err,
  input  logic              ev_collide,
  input  logic              ev_kill_fail,
  input  logic              start_req,
  input  logic              eng_active,
  input  logic              irq_en,
  output logic              eng_go,
  output logic              host_busy,
  output logic              irq
);

  logic [NUM_SRC-1:0] set_ev;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] flags;
  logic [DATA_W-1:0]  status;
  logic               end_evt;
  logic               launch;
  logic               pending;
  logic               busy;

  assign set_ev[SRC_DONE]    = ev_done;
  assign set_ev[SRC_DEVERR]  = ev_dev_err;
  assign set_ev[SRC_COLLIDE] = ev_collide;
  assign set_ev[SRC_KILLED]  = ev_kill_fail;
  assign end_evt             = |set_ev;

  smbst_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (set_ev),
    .clr_mask (clr_mask),
    .flags    (flags)
  );

  smbst_launch_timer #(.LAT(LAT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .eng_active (eng_active),
    .end_evt    (end_evt),
    .launch     (launch),
    .pending    (pending),
    .busy       (busy)
  );

  assign status = pack_status(flags, busy);

  smbst_regport #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_port (
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wflags   (reg_wdata[NUM_SRC:1]),
    .status   (status),
    .rdata    (reg_rdata),
    .clr_mask (clr_mask)
  );

  assign eng_go    = launch;
  assign host_busy = busy;
  assign irq       = irq_combine(irq_en, flags);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000); // R5

  AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(STAT_OFS)) |-> (reg_rdata == 8'h00)); // R10

  AST_BUSY_BIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_OFS)) |-> (reg_rdata[0] == host_busy)); // R6

  AST_RO_BITS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata[0] || (|reg_wdata[7:5])) && !launch && !end_evt)
      |=> (host_busy == $past(host_busy))); // R5

  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> !host_busy); // R8

  AST_PENDING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !host_busy); // R8

endmodule

// File: tb/smb_host_status_bench.sv
module smb_host_status_bench;

  localparam int unsigned BLAT  = 3;
  localparam int unsigned BAW   = 4;
  localparam int unsigned NVEC  = 19;

  // Vector: wr, addr, wdata, ev{kill,collide,deverr,done}, irq_en, expected rdata, expected irq
  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [3:0] ev;
    logic       en;
    logic [7:0] x_rd;
    logic       x_irq;
  } vec_t;

  localparam logic [26:0] VECS [0:NVEC-1] = '{
    {1'b0, 4'h0, 8'h00, 4'b0000, 1'b0, 8'h00, 1'b0}, // 0  idle
    {1'b0, 4'h0, 8'h00, 4'b0001, 1'b0, 8'h02, 1'b0}, // 1  done sets bit1, irq off
    {1'b0, 4'h0, 8'h00, 4'b0000, 1'b1, 8'h02, 1'b1}, // 2  enable raises irq
    {1'b0, 4'h0, 8'h00, 4'b0010, 1'b1, 8'h06, 1'b1}, // 3  device error bit2
    {1'b0, 4'h0, 8'h00, 4'b0100, 1'b1, 8'h0E, 1'b1}, // 4  collision bit3
    {1'b0, 4'h0, 8'h00, 4'b1000, 1'b1, 8'h1E, 1'b1}, // 5  kill failure bit4
    {1'b1, 4'h0, 8'h00, 4'b0000, 1'b1, 8'h1E, 1'b1}, // 6  write zeros keeps
    {1'b1, 4'h0, 8'hE1, 4'b0000, 1'b1, 8'h1E, 1'b1}, // 7  reserved/busy bits ignored
    {1'b1, 4'h1, 8'hFF, 4'b0000, 1'b1, 8'h00, 1'b1}, // 8  other offset reads 0
    {1'b0, 4'h0, 8'h00, 4'b0000, 1'b1, 8'h1E, 1'b1}, // 9  other-offset write no effect
    {1'b1, 4'h0, 8'h02, 4'b0000, 1'b1, 8'h1C, 1'b1}, // 10 clear bit1 only
    {1'b1, 4'h0, 8'h04, 4'b0010, 1'b1, 8'h1C, 1'b1}, // 11 set beats clear bit2
    {1'b1, 4'h0, 8'h1C, 4'b0000, 1'b1, 8'h00, 1'b0}, // 12 clear rest
    {1'b0, 4'h0, 8'h00, 4'b1000, 1'b0, 8'h10, 1'b0}, // 13 kill with irq off
    {1'b0, 4'h0, 8'h00, 4'b0000, 1'b1, 8'h10, 1'b1}, // 14 enable
    {1'b1, 4'h0, 8'h10, 4'b1000, 1'b1, 8'h10, 1'b1}, // 15 set beats clear bit4
    {1'b1, 4'h0, 8'h10, 4'b0000, 1'b1, 8'h00, 1'b0}, // 16 clear bit4
    {1'b0, 4'h0, 8'h00, 4'b0100, 1'b1, 8'h08, 1'b1}, // 17 collision again
    {1'b1, 4'h0, 8'h08, 4'b0000, 1'b1, 8'h00, 1'b0}  // 18 clear bit3
  };

  logic           clk;
  logic           rst_n;
  logic [BAW-1:0] reg_addr;
  logic [7:0]     reg_wdata;
  logic           reg_wr;
  logic [7:0]     reg_rdata;
  logic           ev_done, ev_dev_err, ev_collide, ev_kill_fail;
  logic           start_req, eng_active, irq_en;
  logic           eng_go, host_busy, irq;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic        finished = 1'b0;

  smb_host_status #(.ADDR_W(BAW), .STAT_OFS(0), .LAT(BLAT)) u_smb_host_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rdata    (reg_rdata),
    .ev_done      (ev_done),
    .ev_dev_err   (ev_dev_err),
    .ev_collide   (ev_collide),
    .ev_kill_fail (ev_kill_fail),
    .start_req    (start_req),
    .eng_active   (eng_active),
    .irq_en       (irq_en),
    .eng_go       (eng_go),
    .host_busy    (host_busy),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string vec_req(input int idx);
    case (idx)
      1, 3, 4, 5, 13, 17: return "R2";
      2, 14:              return "R9";
      6, 9, 10, 12, 16, 18: return "R3";
      7:                  return "R5";
      8:                  return "R10";
      11, 15:             return "R4";
      default:            return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    reg_wr = 1'b0; reg_wdata = 8'h00;
    ev_done = 1'b0; ev_dev_err = 1'b0; ev_collide = 1'b0; ev_kill_fail = 1'b0;
    start_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; eng_active = 1'b0; irq_en = 1'b0;
    quiet();
    repeat (3) @(negedge clk);
    check("R1", "reset rdata", reg_rdata, 8'h00);
    check("R1", "reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();
    check("R1", "post-reset rdata", reg_rdata, 8'h00);
    check("R1", "post-reset busy", {7'b0, host_busy}, 8'h00);
    check("R1", "post-reset go", {7'b0, eng_go}, 8'h00);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      reg_wr = v.wr; reg_addr = v.addr; reg_wdata = v.wdata;
      {ev_kill_fail, ev_collide, ev_dev_err, ev_done} = v.ev;
      irq_en = v.en;
      tick();
      quiet();
      check(vec_req(i), $sformatf("vector %0d rdata", i), reg_rdata, v.x_rd);
      check("R9", $sformatf("vector %0d irq", i), {7'b0, irq}, {7'b0, v.x_irq});
    end
    reg_addr = '0;

    // R6: start-to-busy latency, with a second start while pending (R8)
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    check("R6", "busy right after start", {7'b0, host_busy}, 8'h00);
    check("R6", "status bit0 after start", reg_rdata, 8'h00);
    for (int j = 1; j <= int'(BLAT); j++) begin
      if (j == 2) start_req = 1'b1; // R8: ignored while pending
      tick();
      start_req = 1'b0;
      check("R6", $sformatf("busy after edge k+%0d", j), {7'b0, host_busy},
            (j >= int'(BLAT)) ? 8'h01 : 8'h00);
      check("R6", $sformatf("go after edge k+%0d", j), {7'b0, eng_go},
            (j == int'(BLAT) - 1) ? 8'h01 : 8'h00);
    end
    check("R6", "status bit0 busy", reg_rdata, 8'h01);

    // R8: start while busy gives no go strobe
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    for (int j = 0; j < 2 * int'(BLAT); j++) begin
      check("R8", "no go while busy", {7'b0, eng_go}, 8'h00);
      check("R8", "busy holds", {7'b0, host_busy}, 8'h01);
      tick();
    end

    // R7: done pulse ends busy and latches bit1
    ev_done = 1'b1;
    tick();
    quiet();
    check("R7", "busy after done", {7'b0, host_busy}, 8'h00);
    check("R7", "status after done", reg_rdata, 8'h02);
    reg_wr = 1'b1; reg_wdata = 8'h02;
    tick();
    quiet();
    check("R3", "cleared after done", reg_rdata, 8'h00);

    // R8: start while engine active is ignored
    eng_active = 1'b1;
    start_req  = 1'b1;
    tick();
    start_req = 1'b0;
    for (int j = 0; j < int'(BLAT) + 2; j++) begin
      check("R8", "no go while engine active", {7'b0, eng_go}, 8'h00);
      check("R8", "no busy while engine active", {7'b0, host_busy}, 8'h00);
      tick();
    end
    eng_active = 1'b0;

    // R7: kill failure also ends busy
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    repeat (BLAT) tick();
    check("R6", "busy before kill", {7'b0, host_busy}, 8'h01);
    ev_kill_fail = 1'b1;
    tick();
    quiet();
    check("R7", "busy after kill", {7'b0, host_busy}, 8'h00);
    check("R2", "status after kill", reg_rdata, 8'h10);
    check("R9", "irq after kill", {7'b0, irq}, 8'h01);

    // R1: reset in mid-run clears latched flags
    ev_dev_err = 1'b1;
    tick();
    quiet();
    check("R2", "status before reset", reg_rdata, 8'h14);
    rst_n = 1'b0;
    #2;
    check("R1", "rdata in reset", reg_rdata, 8'h00);
    check("R1", "irq in reset", {7'b0, irq}, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1", "rdata after reset", reg_rdata, 8'h00);

    finish_run();
  end

endmodule